// File: doc/BRIEF.md
# DMA Bus Ownership Mode Controller

This block decides when a DMA engine may take the shared system bus away from the CPU. When a peripheral raises a transfer request and a non-zero block length has been programmed, the controller raises a hold request toward the CPU. It moves no data until the CPU answers with a bus grant. The moving of data is reduced to a per-beat strobe with an address; each beat advances the address by a fixed step and lowers the remaining count by one.

Three sharing policies are selectable through a CPU-visible mode register. Burst mode keeps the bus for the whole block. Cycle-stealing mode moves one item and then hands the bus back; it asks again only after the CPU has retired one instruction. Transparent mode keeps the request up but moves an item only in cycles where the CPU reports that it is not using the bus. The CPU programs the start address, the length and the mode through a chip select, a two-bit register select and a write strobe. It can reach these registers only while it owns the bus, that is while the grant is low.

Top module: `dma_bus_owner`

## Requirements
- R1: From idle, a one-cycle `dma_req` with a non-zero length raises `bus_hold`, and no beat (`beat_stb`) occurs while `bus_grant` is low.
- R2: While `bus_hold` is high and `bus_grant` is low, `bus_hold` stays high in the next cycle.
- R3: Every beat drives `mst_addr` equal to the start address plus ADDR_STEP times the number of earlier beats, modulo 2^ADDR_W, and lowers the remaining count by one. A block issues exactly its programmed number of beats.
- R4: Mode 1 (cycle stealing): after each beat except the last, `bus_hold` is low in the next cycle. It rises again only after the grant has gone low and `cpu_instr_done` has been seen, so a block of N beats raises `bus_hold` N times.
- R5: Mode 2 (transparent): a beat occurs only in a cycle where `cpu_bus_idle` is high.
- R6: `mst_drive_en` is high only while `bus_grant` is high, and `mst_addr` reads zero whenever `mst_drive_en` is low.
- R7: If the grant drops during a transfer, that cycle's beat is dropped, `bus_hold` stays high, and the count and address are unchanged until the beat is retried under a new grant.
- R8: `xfer_done` is a single-cycle pulse in the cycle after the last beat, with `bus_hold` already low. It occurs once per block in every mode.
- R9: CPU reads return the selected register only when `cpu_cs` is high and `bus_grant` is low; otherwise `cpu_rdata` is zero and writes are ignored.
- R10: Writes to address, length and mode are ignored while a block is in progress.
- R11: Register select 0 is the current address, 1 the remaining count, 2 the mode (0 burst, 1 cycle stealing, 2 transparent, 3 behaves as burst), and 3 the status with bit 0 set while a block is in progress.
- R12: A `dma_req` while the remaining count is zero is ignored and `bus_hold` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | Peripheral transfer request |
| bus_hold | output | 1 | Bus request toward the CPU |
| bus_grant | input | 1 | Bus granted by the CPU |
| cpu_bus_idle | input | 1 | CPU is not using the bus this cycle |
| cpu_instr_done | input | 1 | CPU retired an instruction |
| cpu_cs | input | 1 | Register chip select |
| cpu_rs | input | 2 | Register select |
| cpu_we | input | 1 | Register write strobe |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data |
| mst_addr | output | ADDR_W | Beat address |
| mst_drive_en | output | 1 | Address outputs are driven |
| beat_stb | output | 1 | One data item moves this cycle |
| xfer_done | output | 1 | Block finished |

## Verification
A state machine stuck in the wrong state shows at the ports within a cycle or two. Hold falls or stays high when it should not, or strobes appear while the grant is low or the CPU is busy. A wrong address or count register shows in the address of the very next beat, in the number of beats before the done pulse, and in the values read back once the bus returns. Wrong gating of register access shows up on the first read made under grant, or on the first write attempted during a block.

// File: rtl/dbo_pkg.sv
package dbo_pkg;
   typedef enum logic [1:0] {
      MODE_BURST  = 2'd0,
      MODE_STEAL  = 2'd1,
      MODE_TRANSP = 2'd2
   } own_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ASK   = 2'd1,
      ST_MOVE  = 2'd2,
      ST_YIELD = 2'd3
   } own_state_e;

   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_CNT  = 2'd1;
   localparam logic [1:0] SEL_MODE = 2'd2;
   localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/dbo_regfile.sv
module dbo_regfile
   import dbo_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 8,
   parameter int DATA_W    = 16,
   parameter int ADDR_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_cs,
   input  logic [1:0]        cpu_rs,
   input  logic              cpu_we,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              bus_grant,
   input  logic              busy,
   input  logic              beat,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  remaining,
   output logic [1:0]        mode,
   output logic [DATA_W-1:0] cpu_rdata
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(ADDR_STEP);
   localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);

   logic access_ok;
   logic wr_ok;
   logic [DATA_W-1:0] rd_val;

   assign access_ok = cpu_cs && !bus_grant;
   assign wr_ok     = access_ok && cpu_we && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr  <= '0;
         remaining <= '0;
         mode      <= MODE_BURST;
      end else if (beat) begin
         cur_addr  <= cur_addr + STEP_V;
         remaining <= remaining - ONE_C;
      end else if (wr_ok) begin
         case (cpu_rs)
            SEL_ADDR: cur_addr  <= cpu_wdata[ADDR_W-1:0];
            SEL_CNT:  remaining <= cpu_wdata[CNT_W-1:0];
            SEL_MODE: mode      <= cpu_wdata[1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      rd_val = '0;
      case (cpu_rs)
         SEL_ADDR: rd_val[ADDR_W-1:0] = cur_addr;
         SEL_CNT:  rd_val[CNT_W-1:0]  = remaining;
         SEL_MODE: rd_val[1:0]        = mode;
         default:  rd_val[0]          = busy;
      endcase
   end

   assign cpu_rdata = (access_ok && !cpu_we) ? rd_val : '0;

   // R3: each beat consumes exactly one count
   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      beat |=> (remaining == $past(remaining) - ONE_C));

   // R10: configuration frozen while busy and no beat
   assert_frozen_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !beat) |=> ($stable(cur_addr) && $stable(mode)));
endmodule

// File: rtl/dbo_fsm.sv
module dbo_fsm
   import dbo_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter bit TRANSP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dreq,
   input  logic             bus_grant,
   input  logic             cpu_idle,
   input  logic             cpu_instr_done,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] remaining,
   output logic             hold,
   output logic             beat,
   output logic             busy,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   own_state_e state, state_nx;
   logic slot_ok;
   logic last;
   logic is_steal;

   generate
      if (TRANSP_EN) begin : g_transp
         assign slot_ok = (mode == MODE_TRANSP) ? cpu_idle : 1'b1;
      end else begin : g_no_transp
         assign slot_ok = 1'b1;
      end
   endgenerate

   assign is_steal = (mode == MODE_STEAL);
   assign last     = (remaining == ONE_C);
   assign beat     = (state == ST_MOVE) && bus_grant && slot_ok;
   assign hold     = (state == ST_ASK) || (state == ST_MOVE);
   assign busy     = (state != ST_IDLE);

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:  if (dreq && remaining != '0) state_nx = ST_ASK;
         ST_ASK:   if (bus_grant) state_nx = ST_MOVE;
         ST_MOVE: begin
            if (!bus_grant)       state_nx = ST_ASK;
            else if (beat && last) state_nx = ST_IDLE;
            else if (beat && is_steal) state_nx = ST_YIELD;
         end
         ST_YIELD: if (!bus_grant && cpu_instr_done) state_nx = ST_ASK;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= beat && last;
      end
   end

   // R2: request held until grant
   assert_hold_until_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !bus_grant) |=> hold);

   // R4: bus handed back after a non-final stolen beat
   assert_steal_yield_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && is_steal && !last) |=> !hold);

   // R8: done is one cycle wide with the request already withdrawn
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !hold);
endmodule

// File: rtl/dma_bus_owner.sv
module dma_bus_owner
   import dbo_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 8,
   parameter int DATA_W    = 16,
   parameter int ADDR_STEP = 2,
   parameter bit TRANSP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_req,
   output logic              bus_hold,
   input  logic              bus_grant,
   input  logic              cpu_bus_idle,
   input  logic              cpu_instr_done,
   input  logic              cpu_cs,
   input  logic [1:0]        cpu_rs,
   input  logic              cpu_we,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [ADDR_W-1:0] mst_addr,
   output logic              mst_drive_en,
   output logic              beat_stb,
   output logic              xfer_done
);
   generate
      if (DATA_W < ADDR_W || DATA_W < CNT_W || DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must cover ADDR_W, CNT_W and the mode field");
      end
      if (ADDR_STEP < 1 || CNT_W < 1 || ADDR_W < 1) begin : g_bad_shape
         $error("ADDR_STEP, CNT_W and ADDR_W must be positive");
      end
   endgenerate

   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  remaining;
   logic [1:0]        mode;
   logic              beat;
   logic              busy;

   dbo_regfile #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_STEP(ADDR_STEP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cpu_cs(cpu_cs), .cpu_rs(cpu_rs), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
      .bus_grant(bus_grant), .busy(busy), .beat(beat),
      .cur_addr(cur_addr), .remaining(remaining), .mode(mode),
      .cpu_rdata(cpu_rdata)
   );

   dbo_fsm #(
      .CNT_W(CNT_W), .TRANSP_EN(TRANSP_EN)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .dreq(dma_req), .bus_grant(bus_grant), .cpu_idle(cpu_bus_idle),
      .cpu_instr_done(cpu_instr_done), .mode(mode), .remaining(remaining),
      .hold(bus_hold), .beat(beat), .busy(busy), .done(xfer_done)
   );

   assign mst_drive_en = beat;
   assign beat_stb     = beat;
   assign mst_addr     = beat ? cur_addr : '0;

   // R6: address driven only under grant
   assert_drive_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mst_drive_en |-> bus_grant);

   // R5: transparent beats only in CPU idle cycles
   assert_transp_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_drive_en && TRANSP_EN && mode == MODE_TRANSP) |-> cpu_bus_idle);

   // R9: register reads blocked under grant
   assert_rdata_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant |-> (cpu_rdata == '0));
endmodule

// File: tb/dma_bus_owner_test.sv
module dma_bus_owner_test;
   localparam int CLK_P = 10;
   localparam int AW = 16;
   localparam int CW = 8;
   localparam int DW = 16;
   localparam int STEP = 2;
   localparam int NV = 4;

   localparam logic [1:0]    V_MODE [NV] = '{2'd0, 2'd1, 2'd2, 2'd3};
   localparam logic [AW-1:0] V_ADDR [NV] = '{16'h0010, 16'h0200, 16'h3000, 16'hFFFC};
   localparam logic [CW-1:0] V_CNT  [NV] = '{8'd5, 8'd4, 8'd6, 8'd3};
   localparam int            V_RISE [NV] = '{1, 4, 1, 1};

   logic clk = 0, rst_n = 0;
   logic dma_req = 0, bus_grant = 0, cpu_bus_idle = 0, cpu_instr_done = 0;
   logic cpu_cs = 0, cpu_we = 0;
   logic [1:0] cpu_rs = 0;
   logic [DW-1:0] cpu_wdata = 0;
   logic [DW-1:0] cpu_rdata;
   logic [AW-1:0] mst_addr;
   logic bus_hold, mst_drive_en, beat_stb, xfer_done;

   int n_chk = 0, n_fail = 0;
   int beats = 0, rises = 0, dones = 0, bad_addr = 0, bad_idle = 0, bad_drv = 0, bad_done = 0;
   logic auto_gnt = 0, transp_chk = 0, prev_hold = 0, prev_done = 0;
   logic [AW-1:0] exp_addr = 0;

   always #(CLK_P/2) clk = ~clk;

   dma_bus_owner #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .ADDR_STEP(STEP)) uut (
      .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .bus_hold(bus_hold),
      .bus_grant(bus_grant), .cpu_bus_idle(cpu_bus_idle), .cpu_instr_done(cpu_instr_done),
      .cpu_cs(cpu_cs), .cpu_rs(cpu_rs), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .mst_addr(mst_addr), .mst_drive_en(mst_drive_en),
      .beat_stb(beat_stb), .xfer_done(xfer_done)
   );

   // cooperative CPU model
   always @(posedge clk) begin
      if (auto_gnt) begin
         bus_grant      <= bus_hold;
         cpu_bus_idle   <= ~cpu_bus_idle;
         cpu_instr_done <= !bus_grant;
      end
   end

   // port monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_hold && !prev_hold) rises++;
         if (beat_stb) begin
            beats++;
            if (mst_addr !== exp_addr) bad_addr++;
            exp_addr = exp_addr + AW'(STEP);
            if (transp_chk && !cpu_bus_idle) bad_idle++;
         end
         if (mst_drive_en && !bus_grant) bad_drv++;
         if (!mst_drive_en && mst_addr !== '0) bad_drv++;
         if (xfer_done) begin
            dones++;
            if (prev_done || bus_hold) bad_done++;
         end
         prev_hold = bus_hold;
         prev_done = xfer_done;
      end
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr_reg(input logic [1:0] rs, input logic [DW-1:0] v);
      cpu_cs = 1; cpu_we = 1; cpu_rs = rs; cpu_wdata = v;
      tick();
      cpu_cs = 0; cpu_we = 0;
   endtask

   task automatic rd_reg(input logic [1:0] rs, output logic [DW-1:0] v);
      cpu_cs = 1; cpu_we = 0; cpu_rs = rs;
      #1 v = cpu_rdata;
      cpu_cs = 0;
   endtask

   task automatic pulse_req();
      dma_req = 1; tick(); dma_req = 0;
   endtask

   task automatic wait_done(output bit seen);
      int d0;
      d0 = dones;
      seen = 0;
      for (int i = 0; i < 2000 && !seen; i++) begin
         tick();
         if (dones != d0) seen = 1;
      end
      tick(); tick(); tick();
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] rv;
      bit seen;
      int b0, r0, d0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      // reset state, R11 map
      chk(bus_hold == 0 && mst_drive_en == 0 && xfer_done == 0, "R6 reset outputs", bus_hold, 0);
      rd_reg(2'd0, rv); chk(rv == 0, "R11 reset addr", rv, 0);
      rd_reg(2'd1, rv); chk(rv == 0, "R11 reset count", rv, 0);
      rd_reg(2'd3, rv); chk(rv == 0, "R11 reset status", rv, 0);

      // R12: zero length ignored
      pulse_req(); tick(); tick();
      chk(bus_hold == 0, "R12 zero count no hold", bus_hold, 0);

      // vector table with cooperative CPU
      auto_gnt = 1;
      for (int v = 0; v < NV; v++) begin
         wr_reg(2'd0, DW'(V_ADDR[v]));
         wr_reg(2'd1, DW'(V_CNT[v]));
         wr_reg(2'd2, DW'(V_MODE[v]));
         rd_reg(2'd2, rv); chk(rv == DW'(V_MODE[v]), "R11 mode readback", rv, V_MODE[v]);
         exp_addr = V_ADDR[v];
         transp_chk = (V_MODE[v] == 2'd2);
         b0 = beats; r0 = rises; d0 = dones;
         pulse_req();
         wait_done(seen);
         chk(seen, "R8 done seen", dones - d0, 1);
         chk(dones - d0 == 1, "R8 one done per block", dones - d0, 1);
         chk(beats - b0 == int'(V_CNT[v]), "R3 beat count", beats - b0, V_CNT[v]);
         chk(rises - r0 == V_RISE[v], "R4 hold raises", rises - r0, V_RISE[v]);
         rd_reg(2'd0, rv);
         chk(rv == DW'(AW'(V_ADDR[v] + AW'(STEP) * AW'(V_CNT[v]))), "R3 final addr", rv,
             AW'(V_ADDR[v] + AW'(STEP) * AW'(V_CNT[v])));
         rd_reg(2'd1, rv); chk(rv == 0, "R3 count drained", rv, 0);
         transp_chk = 0;
      end
      auto_gnt = 0;
      bus_grant = 0; cpu_bus_idle = 0; cpu_instr_done = 0;
      tick(); tick();

      // manual grant: R1, R2, R7, R9, R10
      wr_reg(2'd0, 16'h0100);
      wr_reg(2'd1, 16'd3);
      wr_reg(2'd2, 16'd0);
      exp_addr = 16'h0100;
      b0 = beats;
      pulse_req();
      repeat (4) tick();
      chk(bus_hold == 1, "R2 hold waits for grant", bus_hold, 1);
      chk(beats == b0, "R1 no beat without grant", beats - b0, 0);
      rd_reg(2'd3, rv); chk(rv[0] == 1, "R11 status busy", rv[0], 1);
      bus_grant = 1;
      tick();
      rd_reg(2'd0, rv); chk(rv == 0, "R9 read blocked under grant", rv, 0);
      tick();
      bus_grant = 0;
      tick();
      @(negedge clk);
      chk(bus_hold == 1 && mst_drive_en == 0, "R7 hold kept after grant loss", bus_hold, 1);
      chk(beats - b0 == 1, "R7 dropped beat not counted", beats - b0, 1);
      tick();
      rd_reg(2'd1, rv); chk(rv == 2, "R7 count unchanged", rv, 2);
      rd_reg(2'd0, rv); chk(rv == 16'h0102, "R7 addr unchanged", rv, 16'h0102);
      wr_reg(2'd2, 16'd2);
      wr_reg(2'd0, 16'h5555);
      rd_reg(2'd2, rv); chk(rv == 0, "R10 mode write ignored", rv, 0);
      rd_reg(2'd0, rv); chk(rv == 16'h0102, "R10 addr write ignored", rv, 16'h0102);
      bus_grant = 1;
      d0 = dones;
      for (int i = 0; i < 20 && dones == d0; i++) tick();
      chk(beats - b0 == 3, "R7 retried to completion", beats - b0, 3);
      bus_grant = 0;
      tick(); tick();
      rd_reg(2'd0, rv); chk(rv == 16'h0106, "R3 final addr after retry", rv, 16'h0106);

      chk(bad_addr == 0, "R3 beat addresses", bad_addr, 0);
      chk(bad_idle == 0, "R5 transparent idle slots", bad_idle, 0);
      chk(bad_drv == 0, "R6 drive only under grant", bad_drv, 0);
      chk(bad_done == 0, "R8 done width and release", bad_done, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule